// File: doc/BRIEF.md
# Set-Associative Tag Directory with Line Permissions

This block keeps the tags and per-line state for a set-associative cache controller. It stores no data. For each way of each set it holds an occupancy flag, the line address, a permission state and a lock owner. A controller sends it one command per cycle with a line address. The block answers one cycle later with a hit flag, a way number and a result flag for the command. A probe command also returns the address of the line chosen for eviction.

The commands cover the controller's needs:
- a permission-checked access for a load, instruction fetch or store;
- a raw tag search that ignores permission;
- a room check;
- allocation and release of a line;
- a victim probe;
- a permission update;
- setting, clearing and testing a line lock;
- a query of one chosen set and way for its Invalid and Busy state.

A least-recently-used tracker per set orders the ways. Accesses move a line to most-recently-used. Allocation does the same only when the touch flag is set.

Top module: `tag_directory`

## Requirements
- R1: The set index is `cmd_addr[INDEX_LO +: SET_W]`, where SET_W = log2(CAP_BYTES / WAYS / LINE_BYTES). With the defaults (64-byte lines, 8 sets) this is bits 8:6. Byte-offset bits below the line size are ignored when tags are compared. Sets fill independently.
- R2: Every command with `cmd_valid` high gets exactly one response: `rsp_valid` is high in the cycle after it and in no other cycle.
- R3: Command codes are: 0 access, 1 raw search, 2 room check, 3 allocate, 4 release, 5 probe, 6 lock, 7 unlock, 8 lock test, 9 set permission, 10 way query. Permission codes are: 0 NotPresent, 1 Invalid, 2 ReadOnly, 3 ReadWrite, 4 Busy. A line is present only when its way is occupied, its tag matches, and its permission is not NotPresent. Access and lock commands see only present lines. The raw search (code 1) hits on any occupied way whose tag matches. A miss reports way 0.
- R4: An access (code 0) is granted (`rsp_grant`) only on a present line that is either ReadWrite, or ReadOnly with a request of load (0) or instruction fetch (1). A store (2) to a ReadOnly line is refused, and so is any request to an Invalid line.
- R5: An access that hits a present line makes that way most-recently-used even when the access is refused.
- R6: The room check (code 2) reports `rsp_avail` high when the target set has a way that holds the same line address, a way that is empty, or a way in NotPresent.
- R7: Allocation writes the lowest-numbered way that is empty or NotPresent. The line gets Invalid permission and no lock owner. `rsp_hit` is high and `rsp_way` gives the chosen way. The way becomes most-recently-used only when `cmd_touch` is high.
- R8: Allocating a line that is already present, or allocating into a set with no empty or NotPresent way, sets `err_flag`. The flag stays set until reset, and the failed allocation leaves tags, permissions and replacement order unchanged.
- R9: Releasing (code 4) a present line empties its way, so later searches miss it.
- R10: A probe (code 5) returns, on `rsp_way` and `rsp_victim`, the least-recently-used way of the set and its stored line address. After reset, the ways of each set rank from way 0 (newest) to way WAYS-1 (oldest).
- R11: A lock (code 6) stores `cmd_ctx` as the owner of a present line, and an unlock (code 7) clears it. The lock test (code 8) reports `rsp_lock_match` only when the line is present and its owner equals `cmd_ctx`. The all-ones owner means no owner and never matches.
- R12: The way query (code 10) reads set `cmd_addr[INDEX_LO +: SET_W]`, way `cmd_way`. It reports `rsp_blk_invalid` when that way is occupied with Invalid permission, and `rsp_blk_not_busy` unless the way is occupied with Busy permission.
- R13: Set permission (code 9) writes `cmd_perm` into the way whose tag matches in the raw sense, and reports the hit.
- R14: Synchronous active-high reset empties every way, clears `err_flag` and `rsp_valid`, and restores the replacement order of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | ADDR_W | Line address (offset bits ignored) |
| cmd_req | input | 2 | Request type for access: 0 load, 1 fetch, 2 store |
| cmd_perm | input | 3 | Permission for set-permission command |
| cmd_ctx | input | CTX_W | Lock context |
| cmd_way | input | WAY_W | Way for the way query |
| cmd_touch | input | 1 | Allocation marks the line most-recently-used |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Line found, allocation done, or probe reported |
| rsp_way | output | WAY_W | Way of the hit, allocation or victim |
| rsp_grant | output | 1 | Access allowed by permission |
| rsp_avail | output | 1 | Room check result |
| rsp_lock_match | output | 1 | Lock test result |
| rsp_blk_invalid | output | 1 | Queried way is Invalid |
| rsp_blk_not_busy | output | 1 | Queried way is not Busy |
| rsp_victim | output | ADDR_W | Line address of the probed victim |
| err_flag | output | 1 | Sticky allocation error |

## Verification
The stimulus walks one set through a full fill, then checks the replacement order after refused accesses and after allocation with and without the touch flag. A design that touched only on granted accesses, or touched on every allocation, would name the wrong victim. A line moved to NotPresent has to miss on access yet still hit on the raw search and count as room, and it must be reused by the next allocation. A design that freed or skipped such a line would report the wrong way. Failed allocations, both duplicates and allocations into a full set, are followed by probes and searches to show that nothing moved. Lock tests with a wrong context, after unlock, after reallocation and with the all-ones context must all return false.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [2:0] {
        PERM_ABSENT  = 3'd0,
        PERM_INVALID = 3'd1,
        PERM_RO      = 3'd2,
        PERM_RW      = 3'd3,
        PERM_BUSY    = 3'd4
    } perm_e;

    typedef enum logic [3:0] {
        OP_ACCESS  = 4'd0,
        OP_RAW     = 4'd1,
        OP_AVAIL   = 4'd2,
        OP_ALLOC   = 4'd3,
        OP_FREE    = 4'd4,
        OP_PROBE   = 4'd5,
        OP_LOCK    = 4'd6,
        OP_UNLOCK  = 4'd7,
        OP_LOCKCHK = 4'd8,
        OP_SETPERM = 4'd9,
        OP_WAYINFO = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        REQ_LOAD  = 2'd0,
        REQ_FETCH = 2'd1,
        REQ_STORE = 2'd2
    } req_e;

    // Permission gate for a present line
    function automatic logic perm_allows(input perm_e p, input req_e r);
        case (p)
            PERM_RW: return 1'b1;
            PERM_RO: return (r == REQ_LOAD) || (r == REQ_FETCH);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tagdir_way_search.sv
module tagdir_way_search
    import tagdir_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [ADDR_W-1:0]            line_addr,
    input  logic [WAYS-1:0]              way_valid,
    input  logic [WAYS-1:0][ADDR_W-1:0]  way_tag,
    input  logic [WAYS-1:0][2:0]         way_perm,
    output logic                         raw_hit,
    output logic [WAY_W-1:0]             raw_way,
    output logic                         pres_hit,
    output logic [WAY_W-1:0]             pres_way,
    output logic                         free_any,
    output logic [WAY_W-1:0]             free_way,
    output logic                         avail
);

    logic [WAYS-1:0] tag_eq;
    logic [WAYS-1:0] is_present;
    logic [WAYS-1:0] is_free;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_eq[w]     = way_valid[w] && (way_tag[w] == line_addr);
        assign is_present[w] = tag_eq[w] && (way_perm[w] != PERM_ABSENT);
        assign is_free[w]    = !way_valid[w] || (way_perm[w] == PERM_ABSENT);
    end

    // Lowest-numbered way wins each encoder
    always_comb begin
        raw_hit  = 1'b0;
        raw_way  = '0;
        pres_hit = 1'b0;
        pres_way = '0;
        free_any = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (tag_eq[w]) begin
                raw_hit = 1'b1;
                raw_way = WAY_W'(w);
            end
            if (is_present[w]) begin
                pres_hit = 1'b1;
                pres_way = WAY_W'(w);
            end
            if (is_free[w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
        avail = free_any || raw_hit;
    end

endmodule

// File: rtl/tagdir_lru.sv
module tagdir_lru #(
    parameter int SETS = 8,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] query_set,
    output logic [WAY_W-1:0] victim_way
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    // Age rank per way: 0 newest, WAYS-1 oldest; always a permutation
    logic [WAY_W-1:0] age [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age[touch_set][w] <= '0;
                else if (age[touch_set][w] < age[touch_set][touch_way])
                    age[touch_set][w] <= age[touch_set][w] + 1'b1;
            end
        end
    end

    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (age[query_set][w] == OLDEST)
                victim_way = WAY_W'(w);
    end

    for (genvar s = 0; s < SETS; s++) begin : g_chk
        logic [WAYS-1:0] oldest_flags;
        always_comb
            for (int w = 0; w < WAYS; w++)
                oldest_flags[w] = (age[s][w] == OLDEST);
        AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
            $countones(oldest_flags) == 1); // R10
    end

endmodule

// File: rtl/tag_directory.sv
module tag_directory
    import tagdir_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int CAP_BYTES  = 2048,
    parameter int WAYS       = 4,
    parameter int INDEX_LO   = 6,
    parameter int CTX_W      = 4,
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_req,
    input  logic [2:0]        cmd_perm,
    input  logic [CTX_W-1:0]  cmd_ctx,
    input  logic [WAY_W-1:0]  cmd_way,
    input  logic              cmd_touch,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic              rsp_grant,
    output logic              rsp_avail,
    output logic              rsp_lock_match,
    output logic              rsp_blk_invalid,
    output logic              rsp_blk_not_busy,
    output logic [ADDR_W-1:0] rsp_victim,
    output logic              err_flag
);

    localparam int SETS  = CAP_BYTES / WAYS / LINE_BYTES;
    localparam int SET_W = $clog2(SETS);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_W) - 1'b1);
    localparam logic [CTX_W-1:0]  NO_OWNER  = '1;

    // Directory state
    logic              ent_valid [SETS][WAYS];
    logic [ADDR_W-1:0] ent_tag   [SETS][WAYS];
    logic [2:0]        ent_perm  [SETS][WAYS];
    logic [CTX_W-1:0]  ent_owner [SETS][WAYS];

    logic [ADDR_W-1:0] line_addr;
    logic [SET_W-1:0]  set_idx;
    op_e               op;

    assign line_addr = cmd_addr & LINE_MASK;
    assign set_idx   = cmd_addr[INDEX_LO +: SET_W];
    assign op        = op_e'(cmd_op);

    logic [WAYS-1:0]             s_valid;
    logic [WAYS-1:0][ADDR_W-1:0] s_tag;
    logic [WAYS-1:0][2:0]        s_perm;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            s_valid[w] = ent_valid[set_idx][w];
            s_tag[w]   = ent_tag[set_idx][w];
            s_perm[w]  = ent_perm[set_idx][w];
        end
    end

    logic             raw_hit, pres_hit, free_any, avail;
    logic [WAY_W-1:0] raw_way, pres_way, free_way, victim_way;

    tagdir_way_search #(.WAYS(WAYS), .ADDR_W(ADDR_W)) u_search (
        .line_addr (line_addr),
        .way_valid (s_valid),
        .way_tag   (s_tag),
        .way_perm  (s_perm),
        .raw_hit   (raw_hit),
        .raw_way   (raw_way),
        .pres_hit  (pres_hit),
        .pres_way  (pres_way),
        .free_any  (free_any),
        .free_way  (free_way),
        .avail     (avail)
    );

    logic alloc_ok;
    logic touch_en;
    logic [WAY_W-1:0] touch_way;

    assign alloc_ok  = !pres_hit && free_any;
    assign touch_en  = cmd_valid &&
                       ((op == OP_ACCESS && pres_hit) ||
                        (op == OP_ALLOC && alloc_ok && cmd_touch));
    assign touch_way = (op == OP_ALLOC) ? free_way : pres_way;

    tagdir_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (touch_en),
        .touch_set  (set_idx),
        .touch_way  (touch_way),
        .query_set  (set_idx),
        .victim_way (victim_way)
    );

    logic [2:0] q_perm;
    logic       q_valid;
    assign q_perm  = ent_perm[set_idx][cmd_way];
    assign q_valid = ent_valid[set_idx][cmd_way];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    ent_valid[s][w] <= 1'b0;
                    ent_tag[s][w]   <= '0;
                    ent_perm[s][w]  <= PERM_ABSENT;
                    ent_owner[s][w] <= NO_OWNER;
                end
            end
            rsp_valid        <= 1'b0;
            rsp_hit          <= 1'b0;
            rsp_way          <= '0;
            rsp_grant        <= 1'b0;
            rsp_avail        <= 1'b0;
            rsp_lock_match   <= 1'b0;
            rsp_blk_invalid  <= 1'b0;
            rsp_blk_not_busy <= 1'b0;
            rsp_victim       <= '0;
            err_flag         <= 1'b0;
        end else begin
            rsp_valid        <= cmd_valid;
            rsp_hit          <= 1'b0;
            rsp_way          <= '0;
            rsp_grant        <= 1'b0;
            rsp_avail        <= 1'b0;
            rsp_lock_match   <= 1'b0;
            rsp_blk_invalid  <= 1'b0;
            rsp_blk_not_busy <= 1'b0;
            rsp_victim       <= '0;
            if (cmd_valid) begin
                case (op)
                    OP_ACCESS: begin
                        rsp_hit   <= pres_hit;
                        rsp_way   <= pres_hit ? pres_way : '0;
                        rsp_grant <= pres_hit &&
                                     perm_allows(perm_e'(ent_perm[set_idx][pres_way]),
                                                 req_e'(cmd_req));
                    end
                    OP_RAW: begin
                        rsp_hit <= raw_hit;
                        rsp_way <= raw_hit ? raw_way : '0;
                    end
                    OP_AVAIL: rsp_avail <= avail;
                    OP_ALLOC: begin
                        if (alloc_ok) begin
                            ent_valid[set_idx][free_way] <= 1'b1;
                            ent_tag[set_idx][free_way]   <= line_addr;
                            ent_perm[set_idx][free_way]  <= PERM_INVALID;
                            ent_owner[set_idx][free_way] <= NO_OWNER;
                            rsp_hit <= 1'b1;
                            rsp_way <= free_way;
                        end else begin
                            err_flag <= 1'b1;
                        end
                    end
                    OP_FREE: begin
                        if (pres_hit) ent_valid[set_idx][pres_way] <= 1'b0;
                        rsp_hit <= pres_hit;
                        rsp_way <= pres_hit ? pres_way : '0;
                    end
                    OP_PROBE: begin
                        rsp_hit    <= 1'b1;
                        rsp_way    <= victim_way;
                        rsp_victim <= ent_tag[set_idx][victim_way];
                    end
                    OP_LOCK, OP_UNLOCK: begin
                        if (pres_hit)
                            ent_owner[set_idx][pres_way] <= (op == OP_LOCK) ? cmd_ctx : NO_OWNER;
                        rsp_hit <= pres_hit;
                        rsp_way <= pres_hit ? pres_way : '0;
                    end
                    OP_LOCKCHK: begin
                        rsp_hit <= pres_hit;
                        rsp_way <= pres_hit ? pres_way : '0;
                        rsp_lock_match <= pres_hit &&
                                          (ent_owner[set_idx][pres_way] == cmd_ctx) &&
                                          (cmd_ctx != NO_OWNER);
                    end
                    OP_SETPERM: begin
                        if (raw_hit) ent_perm[set_idx][raw_way] <= cmd_perm;
                        rsp_hit <= raw_hit;
                        rsp_way <= raw_hit ? raw_way : '0;
                    end
                    OP_WAYINFO: begin
                        rsp_blk_invalid  <= q_valid && (q_perm == PERM_INVALID);
                        rsp_blk_not_busy <= !(q_valid && (q_perm == PERM_BUSY));
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_RSP_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid)); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag); // R8
    AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_grant |-> (rsp_hit && rsp_valid)); // R4
    AST_LOCK_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
        rsp_lock_match |-> rsp_hit); // R11
    AST_INVALID_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_blk_invalid |-> rsp_blk_not_busy); // R12

endmodule

// File: tb/test_tag_directory.sv
`timescale 1ns/1ps
module test_tag_directory;
    import tagdir_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cmd_req = '0;
    logic [2:0]  cmd_perm = '0;
    logic [3:0]  cmd_ctx = '0;
    logic [1:0]  cmd_way = '0;
    logic        cmd_touch = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_grant, rsp_avail, rsp_lock_match;
    logic        rsp_blk_invalid, rsp_blk_not_busy, err_flag;
    logic [1:0]  rsp_way;
    logic [31:0] rsp_victim;

    always #5 clk = ~clk;

    tag_directory i_tag_directory (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_req(cmd_req), .cmd_perm(cmd_perm),
        .cmd_ctx(cmd_ctx), .cmd_way(cmd_way), .cmd_touch(cmd_touch),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
        .rsp_grant(rsp_grant), .rsp_avail(rsp_avail),
        .rsp_lock_match(rsp_lock_match), .rsp_blk_invalid(rsp_blk_invalid),
        .rsp_blk_not_busy(rsp_blk_not_busy), .rsp_victim(rsp_victim),
        .err_flag(err_flag)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic issue(input op_e op, input logic [31:0] a, input req_e rq,
                         input perm_e p, input logic [3:0] c,
                         input logic [1:0] wy, input logic t);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_req = rq;
        cmd_perm = p; cmd_ctx = c; cmd_way = wy; cmd_touch = t;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    typedef struct packed {
        op_e         op;
        logic [31:0] addr;
        req_e        req;
        perm_e       perm;
        logic [3:0]  ctx;
        logic        touch;
        logic        ehit;
        logic [1:0]  eway;
        logic        eflag;
        logic [31:0] evic;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 45;
    localparam vec_t TBL [NV] = '{
        '{OP_AVAIL,   32'h000, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0,   4'd6},  // R6
        '{OP_ALLOC,   32'h000, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0,   4'd7},  // R7
        '{OP_ALLOC,   32'h200, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd7},
        '{OP_ALLOC,   32'h400, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0,   4'd7},
        '{OP_ALLOC,   32'h600, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd3, 1'b0, 32'h0,   4'd7},
        '{OP_AVAIL,   32'h800, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,   4'd6},
        '{OP_AVAIL,   32'h200, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0,   4'd6},
        '{OP_ACCESS,  32'h200, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd4},  // R4
        '{OP_SETPERM, 32'h200, REQ_LOAD,  PERM_RO,     4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd13}, // R13
        '{OP_ACCESS,  32'h200, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b1, 32'h0,   4'd4},
        '{OP_ACCESS,  32'h200, REQ_FETCH, PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b1, 32'h0,   4'd4},
        '{OP_ACCESS,  32'h200, REQ_STORE, PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd4},
        '{OP_SETPERM, 32'h400, REQ_LOAD,  PERM_RW,     4'd0, 1'b0, 1'b1, 2'd2, 1'b0, 32'h0,   4'd13},
        '{OP_ACCESS,  32'h400, REQ_STORE, PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd2, 1'b1, 32'h0,   4'd4},
        '{OP_PROBE,   32'h800, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd3, 1'b0, 32'h600, 4'd10}, // R10
        '{OP_ACCESS,  32'h600, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd3, 1'b0, 32'h0,   4'd5},  // R5
        '{OP_PROBE,   32'h800, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h000, 4'd5},
        '{OP_SETPERM, 32'h000, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0,   4'd13},
        '{OP_ACCESS,  32'h000, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,   4'd3},  // R3
        '{OP_RAW,     32'h000, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0,   4'd3},
        '{OP_AVAIL,   32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b1, 32'h0,   4'd6},
        '{OP_ALLOC,   32'h800, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b1, 1'b1, 2'd0, 1'b0, 32'h0,   4'd7},
        '{OP_PROBE,   32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h200, 4'd7},
        '{OP_ALLOC,   32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,   4'd8},  // R8
        '{OP_RAW,     32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,   4'd8},
        '{OP_ALLOC,   32'h400, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,   4'd8},
        '{OP_PROBE,   32'h000, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h200, 4'd8},
        '{OP_FREE,    32'h200, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd9},  // R9
        '{OP_RAW,     32'h200, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,   4'd9},
        '{OP_ALLOC,   32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd7},
        '{OP_LOCK,    32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd5, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd11}, // R11
        '{OP_LOCKCHK, 32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd5, 1'b0, 1'b1, 2'd1, 1'b1, 32'h0,   4'd11},
        '{OP_LOCKCHK, 32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd6, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd11},
        '{OP_UNLOCK,  32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd11},
        '{OP_LOCKCHK, 32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd5, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd11},
        '{OP_LOCK,    32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd3, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd11},
        '{OP_FREE,    32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd9},
        '{OP_ALLOC,   32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd7},
        '{OP_LOCKCHK, 32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd3, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd7},
        '{OP_LOCKCHK, 32'hA00, REQ_LOAD,  PERM_ABSENT, 4'd15,1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd11},
        '{OP_ALLOC,   32'h040, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd0, 1'b0, 32'h0,   4'd1},  // R1
        '{OP_ALLOC,   32'h1040,REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd1, 1'b0, 32'h0,   4'd1},
        '{OP_ACCESS,  32'h440, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,   4'd1},
        '{OP_ACCESS,  32'h404, REQ_STORE, PERM_ABSENT, 4'd0, 1'b0, 1'b1, 2'd2, 1'b1, 32'h0,   4'd1},
        '{OP_LOCKCHK, 32'hC00, REQ_LOAD,  PERM_ABSENT, 4'd0, 1'b0, 1'b0, 2'd0, 1'b0, 32'h0,   4'd11}
    };

    function automatic logic pick_flag(input op_e op);
        case (op)
            OP_ACCESS:  return rsp_grant;
            OP_AVAIL:   return rsp_avail;
            OP_LOCKCHK: return rsp_lock_match;
            default:    return 1'b0;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R14 rsp_valid after reset", rsp_valid, 0);
        chk("R14 err_flag after reset", err_flag, 0);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].addr, TBL[i].req, TBL[i].perm,
                  TBL[i].ctx, 2'd0, TBL[i].touch);
            chk($sformatf("R%0d row %0d hit", TBL[i].rq, i), rsp_hit, TBL[i].ehit);
            chk($sformatf("R%0d row %0d way", TBL[i].rq, i), rsp_way, TBL[i].eway);
            chk($sformatf("R%0d row %0d flag", TBL[i].rq, i), pick_flag(TBL[i].op), TBL[i].eflag);
            if (TBL[i].op == OP_PROBE)
                chk($sformatf("R%0d row %0d victim", TBL[i].rq, i), rsp_victim, TBL[i].evic);
        end

        chk("R8 err_flag sticky", err_flag, 1);

        // R2: one response per command
        issue(OP_RAW, 32'h400, REQ_LOAD, PERM_ABSENT, 4'd0, 2'd0, 1'b0);
        chk("R2 rsp_valid after command", rsp_valid, 1);
        @(negedge clk);
        chk("R2 rsp_valid idle", rsp_valid, 0);

        // R12: way query
        issue(OP_WAYINFO, 32'h000, REQ_LOAD, PERM_ABSENT, 4'd0, 2'd1, 1'b0);
        chk("R12 invalid way inv", rsp_blk_invalid, 1);
        chk("R12 invalid way notbusy", rsp_blk_not_busy, 1);
        issue(OP_WAYINFO, 32'h000, REQ_LOAD, PERM_ABSENT, 4'd0, 2'd2, 1'b0);
        chk("R12 rw way inv", rsp_blk_invalid, 0);
        issue(OP_SETPERM, 32'h400, REQ_LOAD, PERM_BUSY, 4'd0, 2'd0, 1'b0);
        issue(OP_WAYINFO, 32'h000, REQ_LOAD, PERM_ABSENT, 4'd0, 2'd2, 1'b0);
        chk("R12 busy way notbusy", rsp_blk_not_busy, 0);
        issue(OP_WAYINFO, 32'h080, REQ_LOAD, PERM_ABSENT, 4'd0, 2'd0, 1'b0);
        chk("R12 empty way inv", rsp_blk_invalid, 0);
        chk("R12 empty way notbusy", rsp_blk_not_busy, 1);

        // R14: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R14 err_flag cleared", err_flag, 0);
        issue(OP_RAW, 32'h400, REQ_LOAD, PERM_ABSENT, 4'd0, 2'd0, 1'b0);
        chk("R14 directory emptied", rsp_hit, 0);
        issue(OP_PROBE, 32'h000, REQ_LOAD, PERM_ABSENT, 4'd0, 2'd0, 1'b0);
        chk("R10 reset victim order", rsp_way, 3);
        issue(OP_AVAIL, 32'h600, REQ_LOAD, PERM_ABSENT, 4'd0, 2'd0, 1'b0);
        chk("R14 room after reset", rsp_avail, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule